// File: doc/BRIEF.md
# Flash Record Append Sequencer

This block adds one tagged record to the end of a record list kept in a word-addressed flash block. Erased flash reads as all ones, and programming can only clear bits. A caller presents a record ID, a length in 32-bit words and a stream of data words. The sequencer walks the existing list from the first record slot to the first empty status word. It checks that the whole record fits, counting the status word, the header word and the data words. It then programs the record in a fixed order, so that a write cut short is never read back as good data.

The order is: the status word is set to the invalid pattern, then the header word is written, then the data words, and last the status word is set to the valid pattern. Both status patterns clear only whole bytes of the 32-bit checkbase. This keeps the reprogram of the status word legal under word ECC. The invalid pattern is one fixed constant, so a retry after a marginal first write programs the same value again. If the record does not fit, the block writes nothing and answers "full", so that an outside agent can swap blocks.

Top module: `rec_append_seq`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, and `pg_req`, `rsp_valid` and `dat_take` are 0.
- R2: Word 0 holds the block status and the first record starts at word 1. The walk reads a status word at each record start. A status of 0xFFFF_FFFF ends the list there. Any other status makes the walk read the header at the next word, and the next record starts at record start + 2 + the size held in header bits [15:0].
- R3: During the walk, a header whose size field [15:0] reads 0xFFFF counts as size 0. Such a record therefore takes two words.
- R4: An accepted record is programmed in this order. First the status word at the record start, with 0x0000_FFFF. Then the header at start+1. Then the data words at start+2 onward, in arrival order. Last, 0x0000_0000 at the record start.
- R5: Every program operation only clears bits of the word it targets. The two status values differ from the erased value and from each other in whole bytes only.
- R6: The header word carries the record ID in bits [31:16] and the data size in words in bits [15:0].
- R7: A record is written only if start + 2 + size <= BLK_WORDS. A record that ends exactly at the last word of the block is accepted.
- R8: If the record does not fit, including the case where the walk reaches the end of the block without finding an empty status, the block returns `rsp_full`=1 and issues no program operation. The flash contents do not change.
- R9: `pg_req` carries one word and lasts one cycle. It is never raised while `pg_busy` is 1. No new request is raised until `pg_done` has returned for the previous one.
- R10: A successful append ends with `rsp_valid`=1 and `rsp_full`=0 in the cycle after the `pg_done` of the final status write. `rsp_addr` then gives the record start.
- R11: `dat_take` pulses exactly once per data word. A record of size 0 takes no data and programs only the status, header and status words.
- R12: Word 0, the block status, is never programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Append request present |
| req_ready | output | 1 | Block idle; request accepted when both are high |
| req_id | input | 16 | Record ID |
| req_size | input | 16 | Data length in 32-bit words |
| dat_word | input | 32 | Current data word of the stream |
| dat_take | output | 1 | Data word consumed at this edge |
| fl_rd_addr | output | AW | Flash read address (combinational read) |
| fl_rd_data | input | 32 | Flash read data for `fl_rd_addr` |
| pg_req | output | 1 | One-cycle program request |
| pg_addr | output | AW | Program word address |
| pg_data | output | 32 | Program word value (AND into flash) |
| pg_busy | input | 1 | Flash program in progress |
| pg_done | input | 1 | One-cycle program completion |
| rsp_valid | output | 1 | One-cycle response |
| rsp_full | output | 1 | Record did not fit; swap needed |
| rsp_addr | output | AW | Start word of the written record |

## Verification
A wrong walk state shows up as a wrong `rsp_addr` or as a false full answer as soon as the response appears. The first `pg_addr` issued for the record already exposes it. A slip in the write sequencer shows up in the ordered log of program operations: a status word written out of turn, a header with its fields swapped, or a data word out of order or missing. The flash contents read after the response confirm this. Handshake faults show up in the same cycle they happen, as a request during busy or a request with no done before it. A late or early response shows up one cycle after the final done.

// File: rtl/recapp_pkg.sv
package recapp_pkg;
    localparam int WORD_W = 32;
    localparam int ID_W   = 16;
    localparam int SZ_W   = 16;

    localparam logic [WORD_W-1:0] REC_EMPTY   = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] REC_INVALID = 32'h0000_FFFF;
    localparam logic [WORD_W-1:0] REC_VALID   = 32'h0000_0000;
    localparam logic [SZ_W-1:0]   SZ_BLANK    = 16'hFFFF;

    typedef enum logic [1:0] {WK_IDLE, WK_STAT, WK_HDR} walk_st_e;
    typedef enum logic [1:0] {HS_IDLE, HS_PEND, HS_WAIT} hs_st_e;
    typedef enum logic [2:0] {SQ_IDLE, SQ_SCAN, SQ_FIT, SQ_INV, SQ_HDR, SQ_DAT, SQ_VAL} seq_st_e;

    function automatic logic [WORD_W-1:0] pack_hdr(input logic [ID_W-1:0] id,
                                                   input logic [SZ_W-1:0] sz);
        return {id, sz};
    endfunction
endpackage

// File: rtl/recapp_walk.sv
module recapp_walk
    import recapp_pkg::*;
#(
    parameter int BLK_WORDS = 48,
    localparam int AW    = $clog2(BLK_WORDS),
    localparam int SUM_W = AW + SZ_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              done,
    output logic [AW:0]       end_addr
);
    typedef struct packed {
        walk_st_e    st;
        logic [AW:0] cur;
        logic [AW:0] end_a;
        logic        done;
    } walk_t;

    walk_t q, d;
    logic [SZ_W-1:0]  sz_eff;
    logic [SUM_W-1:0] nxt;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sz_eff = (rd_data[SZ_W-1:0] == SZ_BLANK) ? '0 : rd_data[SZ_W-1:0];
        nxt    = SUM_W'(q.cur) + SUM_W'(2) + SUM_W'(sz_eff);
        case (q.st)
            WK_IDLE: begin
                if (start) begin
                    d.cur = (AW+1)'(1);
                    d.st  = WK_STAT;
                end
            end
            WK_STAT: begin
                if (q.cur >= (AW+1)'(BLK_WORDS)) begin
                    d.end_a = (AW+1)'(BLK_WORDS);
                    d.done  = 1'b1;
                    d.st    = WK_IDLE;
                end else if (rd_data == REC_EMPTY) begin
                    d.end_a = q.cur;
                    d.done  = 1'b1;
                    d.st    = WK_IDLE;
                end else if (q.cur + (AW+1)'(1) >= (AW+1)'(BLK_WORDS)) begin
                    d.end_a = (AW+1)'(BLK_WORDS);
                    d.done  = 1'b1;
                    d.st    = WK_IDLE;
                end else begin
                    d.st = WK_HDR;
                end
            end
            WK_HDR: begin
                if (nxt >= SUM_W'(BLK_WORDS)) begin
                    d.end_a = (AW+1)'(BLK_WORDS);
                    d.done  = 1'b1;
                    d.st    = WK_IDLE;
                end else begin
                    d.cur = nxt[AW:0];
                    d.st  = WK_STAT;
                end
            end
            default: d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= WK_IDLE;
            q.cur   <= '0;
            q.end_a <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_addr  = (q.st == WK_HDR) ? (q.cur[AW-1:0] + AW'(1)) : q.cur[AW-1:0];
    assign done     = q.done;
    assign end_addr = q.end_a;

    // R2
    walk_end_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (end_addr >= (AW+1)'(1) && end_addr <= (AW+1)'(BLK_WORDS)))
        else $error("walk end out of range");
endmodule

// File: rtl/recapp_pgm.sv
module recapp_pgm
    import recapp_pkg::*;
#(
    parameter int BLK_WORDS = 48,
    localparam int AW = $clog2(BLK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [AW-1:0]     go_addr,
    input  logic [WORD_W-1:0] go_data,
    output logic              idle,
    output logic              ack,
    output logic              pg_req,
    output logic [AW-1:0]     pg_addr,
    output logic [WORD_W-1:0] pg_data,
    input  logic              pg_busy,
    input  logic              pg_done
);
    typedef struct packed {
        hs_st_e            st;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] data;
    } hs_t;

    hs_t q, d;

    always_comb begin
        d      = q;
        pg_req = 1'b0;
        ack    = 1'b0;
        case (q.st)
            HS_IDLE: begin
                if (go) begin
                    d.addr = go_addr;
                    d.data = go_data;
                    d.st   = HS_PEND;
                end
            end
            HS_PEND: begin
                if (!pg_busy) begin
                    pg_req = 1'b1;
                    d.st   = HS_WAIT;
                end
            end
            HS_WAIT: begin
                if (pg_done) begin
                    ack  = 1'b1;
                    d.st = HS_IDLE;
                end
            end
            default: d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= HS_IDLE;
            q.addr <= '0;
            q.data <= '0;
        end else begin
            q <= d;
        end
    end

    assign idle    = (q.st == HS_IDLE);
    assign pg_addr = q.addr;
    assign pg_data = q.data;

    // R9
    req_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |-> !pg_busy) else $error("program request while busy");
    // R9
    single_cycle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |=> !pg_req) else $error("program request longer than one cycle");
endmodule

// File: rtl/rec_append_seq.sv
module rec_append_seq
    import recapp_pkg::*;
#(
    parameter int BLK_WORDS = 48,
    localparam int AW    = $clog2(BLK_WORDS),
    localparam int SUM_W = AW + SZ_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [WORD_W-1:0] dat_word,
    output logic              dat_take,
    output logic [AW-1:0]     fl_rd_addr,
    input  logic [WORD_W-1:0] fl_rd_data,
    output logic              pg_req,
    output logic [AW-1:0]     pg_addr,
    output logic [WORD_W-1:0] pg_data,
    input  logic              pg_busy,
    input  logic              pg_done,
    output logic              rsp_valid,
    output logic              rsp_full,
    output logic [AW-1:0]     rsp_addr
);
    typedef struct packed {
        seq_st_e         st;
        logic            sent;
        logic [AW:0]     base;
        logic [ID_W-1:0] id;
        logic [SZ_W-1:0] size;
        logic [SZ_W-1:0] cnt;
        logic            rsp_v;
        logic            rsp_f;
        logic [AW-1:0]   rsp_a;
        logic            seen;
    } seq_t;

    seq_t q, d;

    logic              walk_start, walk_done;
    logic [AW:0]       walk_end;
    logic              go, hs_idle, hs_ack;
    logic [AW-1:0]     go_addr;
    logic [WORD_W-1:0] go_data;
    logic [SUM_W-1:0]  need;
    logic [SUM_W-1:0]  dat_addr;

    recapp_walk #(.BLK_WORDS(BLK_WORDS)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (walk_start),
        .rd_addr  (fl_rd_addr),
        .rd_data  (fl_rd_data),
        .done     (walk_done),
        .end_addr (walk_end)
    );

    recapp_pgm #(.BLK_WORDS(BLK_WORDS)) u_pgm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .go_addr (go_addr),
        .go_data (go_data),
        .idle    (hs_idle),
        .ack     (hs_ack),
        .pg_req  (pg_req),
        .pg_addr (pg_addr),
        .pg_data (pg_data),
        .pg_busy (pg_busy),
        .pg_done (pg_done)
    );

    always_comb begin
        d          = q;
        d.rsp_v    = 1'b0;
        walk_start = 1'b0;
        go         = 1'b0;
        go_addr    = '0;
        go_data    = '0;
        dat_take   = 1'b0;
        need       = SUM_W'(q.base) + SUM_W'(2) + SUM_W'(q.size);
        dat_addr   = SUM_W'(q.base) + SUM_W'(2) + SUM_W'(q.cnt);
        if (pg_req) d.seen = 1'b1;
        if (hs_ack) d.sent = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    d.id       = req_id;
                    d.size     = req_size;
                    d.seen     = 1'b0;
                    walk_start = 1'b1;
                    d.st       = SQ_SCAN;
                end
            end
            SQ_SCAN: begin
                if (walk_done) begin
                    d.base = walk_end;
                    d.st   = SQ_FIT;
                end
            end
            SQ_FIT: begin
                if (need <= SUM_W'(BLK_WORDS)) begin
                    d.st = SQ_INV;
                end else begin
                    d.rsp_v = 1'b1;
                    d.rsp_f = 1'b1;
                    d.rsp_a = '0;
                    d.st    = SQ_IDLE;
                end
            end
            SQ_INV: begin
                go_addr = q.base[AW-1:0];
                go_data = REC_INVALID;
                if (!q.sent && hs_idle) begin
                    go     = 1'b1;
                    d.sent = 1'b1;
                end
                if (hs_ack) d.st = SQ_HDR;
            end
            SQ_HDR: begin
                go_addr = q.base[AW-1:0] + AW'(1);
                go_data = pack_hdr(q.id, q.size);
                if (!q.sent && hs_idle) begin
                    go     = 1'b1;
                    d.sent = 1'b1;
                end
                if (hs_ack) begin
                    d.cnt = '0;
                    d.st  = (q.size == '0) ? SQ_VAL : SQ_DAT;
                end
            end
            SQ_DAT: begin
                go_addr = dat_addr[AW-1:0];
                go_data = dat_word;
                if (!q.sent && hs_idle) begin
                    go       = 1'b1;
                    dat_take = 1'b1;
                    d.sent   = 1'b1;
                    d.cnt    = q.cnt + SZ_W'(1);
                end
                if (hs_ack && q.cnt == q.size) d.st = SQ_VAL;
            end
            SQ_VAL: begin
                go_addr = q.base[AW-1:0];
                go_data = REC_VALID;
                if (!q.sent && hs_idle) begin
                    go     = 1'b1;
                    d.sent = 1'b1;
                end
                if (hs_ack) begin
                    d.rsp_v = 1'b1;
                    d.rsp_f = 1'b0;
                    d.rsp_a = q.base[AW-1:0];
                    d.st    = SQ_IDLE;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= SQ_IDLE;
            q.sent  <= 1'b0;
            q.base  <= '0;
            q.id    <= '0;
            q.size  <= '0;
            q.cnt   <= '0;
            q.rsp_v <= 1'b0;
            q.rsp_f <= 1'b0;
            q.rsp_a <= '0;
            q.seen  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == SQ_IDLE);
    assign rsp_valid = q.rsp_v;
    assign rsp_full  = q.rsp_f;
    assign rsp_addr  = q.rsp_a;

    // R5
    status_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_req && SUM_W'(pg_addr) == SUM_W'(q.base)) |-> (pg_data == REC_INVALID || pg_data == REC_VALID))
        else $error("illegal status pattern");
    // R8
    full_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_full) |-> !q.seen) else $error("program issued before full answer");
    // R7
    addr_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |-> (SUM_W'(pg_addr) < SUM_W'(BLK_WORDS))) else $error("program outside block");
    // R12
    blk_status_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |-> (pg_addr != '0)) else $error("block status programmed");
endmodule

// File: tb/tb_rec_append_seq.sv
module tb_rec_append_seq;
    localparam int CLK_PERIOD = 10;
    localparam int BLK = 48;
    localparam int AW  = $clog2(BLK);

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        req_valid = 1'b0, req_ready, dat_take;
    logic [15:0] req_id = '0, req_size = '0;
    logic [31:0] dat_word, fl_rd_data, pg_data;
    logic [AW-1:0] fl_rd_addr, pg_addr, rsp_addr;
    logic        pg_req, rsp_valid, rsp_full;
    logic        pg_busy, pg_done;

    rec_append_seq #(.BLK_WORDS(BLK)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_size(req_size), .dat_word(dat_word), .dat_take(dat_take),
        .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data), .pg_req(pg_req),
        .pg_addr(pg_addr), .pg_data(pg_data), .pg_busy(pg_busy), .pg_done(pg_done),
        .rsp_valid(rsp_valid), .rsp_full(rsp_full), .rsp_addr(rsp_addr));

    // flash model: word array, AND-programming, command inputs from tasks
    logic [31:0] mem [BLK];
    logic [31:0] src [64];
    logic [31:0] log_data [64];
    int          log_addr [64];
    int          log_n = 0, ptr = 0, lat = 1, viol = 0, up_bits = 0, r10_bad = 0;
    logic        busy_q = 1'b0, done_q = 1'b0, erase_cmd = 1'b0, clr_cmd = 1'b0, pl_en = 1'b0;
    int          cnt_q = 0, pl_addr = 0;
    logic [31:0] pl_data = '0, d_q = '0;
    logic [AW-1:0] a_q = '0;

    assign pg_busy    = busy_q;
    assign pg_done    = done_q;
    assign fl_rd_data = (int'(fl_rd_addr) < BLK) ? mem[fl_rd_addr] : 32'hFFFF_FFFF;
    assign dat_word   = src[ptr[5:0]];

    always @(posedge clk) begin
        done_q <= 1'b0;
        if (dat_take) ptr <= ptr + 1;
        if (erase_cmd) begin
            for (int i = 0; i < BLK; i++) mem[i] <= 32'hFFFF_FFFF;
            mem[0] <= 32'h0000_00FF;
        end else if (pl_en) mem[pl_addr] <= pl_data;
        if (erase_cmd || clr_cmd) begin log_n <= 0; ptr <= 0; end
        if (pg_req) begin
            if (busy_q) viol <= viol + 1;
            busy_q <= 1'b1; cnt_q <= lat; a_q <= pg_addr; d_q <= pg_data;
        end else if (busy_q) begin
            if (cnt_q == 0) begin
                busy_q <= 1'b0; done_q <= 1'b1;
                if ((d_q & ~mem[a_q]) != 0) up_bits <= up_bits + 1;
                mem[a_q] <= mem[a_q] & d_q;
                log_addr[log_n[5:0]] <= int'(a_q);
                log_data[log_n[5:0]] <= d_q;
                log_n <= log_n + 1;
            end else cnt_q <= cnt_q - 1;
        end
    end

    // R10 monitor: success response one cycle after a done
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !rsp_full && !prev_done) r10_bad = r10_bad + 1;
        prev_done = pg_done;
    end

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic erase();
        @(negedge clk); erase_cmd = 1'b1;
        @(negedge clk); erase_cmd = 1'b0;
    endtask

    task automatic clr_log();
        @(negedge clk); clr_cmd = 1'b1;
        @(negedge clk); clr_cmd = 1'b0;
    endtask

    task automatic preload(input int a, input logic [31:0] v);
        @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = v;
        @(negedge clk); pl_en = 1'b0;
    endtask

    task automatic fill_src(input int seed);
        for (int i = 0; i < 64; i++) src[i] = 32'hA500_0000 ^ (seed << 8) ^ i;
    endtask

    task automatic append(input logic [15:0] id, input logic [15:0] sz,
                          output bit full, output int addr);
        int n;
        @(negedge clk); req_valid = 1'b1; req_id = id; req_size = sz;
        @(negedge clk); req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
        full = rsp_full; addr = int'(rsp_addr);
        check(n < 2000, "R10 response arrives", n, 0);
    endtask

    // ordered program log for one record: R4, R5, R6, R11
    task automatic check_record(input int base, input logic [15:0] id, input int sz, input string req);
        int bad;
        bad = 0;
        if (log_n != sz + 3) bad++;
        else begin
            if (log_addr[0] != base || log_data[0] != 32'h0000_FFFF) bad++;
            if (log_addr[1] != base + 1 || log_data[1] != {id, sz[15:0]}) bad++;
            for (int i = 0; i < sz; i++)
                if (log_addr[2+i] != base + 2 + i || log_data[2+i] != src[i]) bad++;
            if (log_addr[sz+2] != base || log_data[sz+2] != 32'h0) bad++;
        end
        check(bad == 0, req, bad, 0);
        check(ptr == sz, "R11 one take per data word", ptr, sz);
        check(mem[base] == 32'h0, "R4 status ends valid", mem[base], 0);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(pg_req == 1'b0 && rsp_valid == 1'b0 && dat_take == 1'b0, "R1 quiet outputs",
              {pg_req, rsp_valid, dat_take}, 0);
    endtask

    task automatic t_empty_and_second();
        bit f; int a;
        erase(); fill_src(1);
        append(16'h1234, 16'd3, f, a);
        check(!f && a == 1, "R12 first record at word 1", a, 1);
        check_record(1, 16'h1234, 3, "R4 R6 order and header");
        check(mem[0] == 32'h0000_00FF, "R12 block status untouched", mem[0], 32'hFF);
        clr_log(); fill_src(2);
        append(16'h0042, 16'd2, f, a);
        check(!f && a == 6, "R2 walk to next empty", a, 6);
        check_record(6, 16'h0042, 2, "R4 second record order");
    endtask

    task automatic t_skip_invalid();
        bit f; int a;
        erase();
        preload(1, 32'h0); preload(2, 32'h0005_0002);
        preload(5, 32'h0000_FFFF);
        preload(7, 32'h0000_FFFF); preload(8, 32'h0006_0001);
        clr_log(); fill_src(3);
        append(16'h0009, 16'd1, f, a);
        check(!f && a == 10, "R3 blank header counts as size 0", a, 10);
        check_record(10, 16'h0009, 1, "R4 after skipped records");
    endtask

    task automatic t_zero_size();
        bit f; int a;
        erase(); fill_src(4);
        append(16'h00AB, 16'd0, f, a);
        check(!f && a == 1, "R11 zero size placed", a, 1);
        check_record(1, 16'h00AB, 0, "R11 zero size writes three words");
    endtask

    task automatic t_full_and_exact();
        bit f; int a;
        erase();
        preload(1, 32'h0); preload(2, 32'h0007_0028);
        clr_log(); fill_src(5);
        append(16'h0011, 16'd4, f, a);
        check(f == 1'b1, "R8 full when one word short", f, 1);
        check(log_n == 0, "R8 no program when full", log_n, 0);
        check(mem[43] == 32'hFFFF_FFFF, "R8 flash unchanged", mem[43], 32'hFFFF_FFFF);
        check(ptr == 0, "R8 no data taken", ptr, 0);
        clr_log();
        append(16'h0012, 16'd3, f, a);
        check(!f && a == 43, "R7 exact fit accepted", a, 43);
        check_record(43, 16'h0012, 3, "R7 exact fit record");
        check(mem[47] == src[2], "R7 last word of block", mem[47], src[2]);
    endtask

    task automatic t_no_empty();
        bit f; int a;
        erase();
        preload(1, 32'h0); preload(2, 32'h0008_002D);
        clr_log();
        append(16'h0013, 16'd0, f, a);
        check(f == 1'b1, "R8 no empty slot gives full", f, 1);
        check(log_n == 0, "R8 nothing programmed", log_n, 0);
    endtask

    task automatic t_slow_flash();
        bit f; int a;
        lat = 6;
        erase(); fill_src(6);
        append(16'h0F0F, 16'd2, f, a);
        check(!f && a == 1, "R9 slow flash placement", a, 1);
        check_record(1, 16'h0F0F, 2, "R9 slow flash order");
        check(viol == 0, "R9 no request while busy", viol, 0);
        lat = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_and_second();
        t_skip_invalid();
        t_zero_size();
        t_full_and_exact();
        t_no_empty();
        t_slow_flash();
        check(up_bits == 0, "R5 programs only clear bits", up_bits, 0);
        check(viol == 0, "R9 one outstanding request", viol, 0);
        check(r10_bad == 0, "R10 response follows done", r10_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule